// File: doc/BRIEF.md
# Multi-depth bitmap read address generator

This block turns the raster timing of a bitmap display window into byte read addresses for video memory. Pixels may be 1, 2, 4 or 8 bits deep. A wide-pixel mode stores each pixel in two bytes. The block keeps two pointers, both counted in bits. The line-start pointer marks where the current raster line begins in memory. The current pointer walks along the line one source pixel at a time. The three low bits of the current pointer give the bit position of a pixel within its byte. The remaining bits give the byte address.

In wide-pixel mode the byte part of the current pointer is doubled on the way out. To compensate, the base address and the line stride are scaled by four instead of eight before they enter the pointers. As a result the sub-byte bit counting is the same in every mode, and each full byte step moves the output address by two.

A horizontal repeat counter stretches each source pixel over 1 to 16 output ticks. Everything stops while the window is inactive. The byte address and the bit index are taken straight from the pointer registers, so they change in the cycle after the clock edge that samples a trigger.

Top module: `bmp_addr_gen`

## Requirements
- R1: After reset is released, byte_addr_o is 0 and bit_idx_o is 0.
- R2: A cycle with first_line_i high loads both pointers. From the next cycle, byte_addr_o equals base_i and bit_idx_o equals sub_off_i. In wide mode (mode16_i=1) this holds when base_i is even.
- R3: In normal mode, each pixel step advances the current pointer by 2^depth_i bits. The encodings are depth_i 0=1, 1=2, 2=4 and 3=8 bits per pixel. bit_idx_o is pointer bits [2:0] and byte_addr_o is the pointer shifted right by 3.
- R4: In wide mode, byte_addr_o is twice the pointer's byte part. With depth_i=3, each step adds 2 to byte_addr_o. The sub-byte bit counting is the same as in normal mode.
- R5: A cycle with line_adv_i high adds stride_i bytes to the line start. The current pointer is set to the new line start, whatever pixels were consumed on the line. In wide mode this holds for an even stride_i.
- R6: While the window is active, a pixel step happens on every (rep_i+1)-th cycle with pix_en_i high. The repeat count restarts on first_line_i and on line_adv_i.
- R7: While win_active_i is low, the pointers and the repeat count hold, even if pix_en_i is high.
- R8: first_line_i takes priority over line_adv_i, and line_adv_i takes priority over a pixel step in the same cycle.
- R9: The bit pointer wraps modulo 2^(ADDR_W+3). A step past the last byte of the address space wraps byte_addr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| first_line_i | input | 1 | First active line: load both pointers |
| line_adv_i | input | 1 | Advance to the next line |
| pix_en_i | input | 1 | Output pixel tick |
| win_active_i | input | 1 | Window is active |
| base_i | input | ADDR_W | Window base byte address |
| stride_i | input | STRIDE_W | Bytes per source line |
| sub_off_i | input | 3 | Horizontal bit offset in the first byte |
| depth_i | input | 2 | Bits per pixel select (0..3 gives 1, 2, 4, 8) |
| mode16_i | input | 1 | Wide two-byte pixel mode |
| rep_i | input | REP_W | Horizontal repeat count minus one |
| byte_addr_o | output | ADDR_W | Byte read address |
| bit_idx_o | output | 3 | Bit index of the pixel within the byte |

## Verification
Every trigger and every pixel tick is captured on one clock edge. Both outputs show the result from that edge on, because they are decoded straight from the pointer registers with no extra stage. The bench drives inputs at the falling edge, lets exactly one rising edge pass, clears the pulses, and checks at the following falling edge. Repeat-count checks therefore expect the pixel step exactly on the (rep_i+1)-th tick. The bench samples after each tick, so an early or late step is seen.

// File: rtl/bmp_addr_pkg.sv
package bmp_addr_pkg;

  localparam int unsigned BIT_W = 3;  // bit index within a byte

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_STEP,
    OP_LINE,
    OP_LOAD
  } ptr_op_e;

endpackage

// File: rtl/bmp_hrep.sv
module bmp_hrep #(
  parameter int unsigned REP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             step_o
);

  logic [REP_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == rep_i);
  assign step_o = tick_i & wrap & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bmp_scale.sv
module bmp_scale #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 16,
  localparam int unsigned PTR_W   = ADDR_W + bmp_addr_pkg::BIT_W
) (
  input  logic [ADDR_W-1:0]              base_i,
  input  logic [STRIDE_W-1:0]            stride_i,
  input  logic [bmp_addr_pkg::BIT_W-1:0] sub_off_i,
  input  logic                           mode16_i,
  input  bmp_addr_pkg::depth_e           depth_i,
  output logic [PTR_W-1:0]               start_o,
  output logic [PTR_W-1:0]               stride_o,
  output logic [PTR_W-1:0]               step_o
);

  logic [PTR_W-1:0] base_x8, base_x4, strd_x8, strd_x4;

  // byte -> bit scaling; wide mode uses one shift less, output undoes it
  assign base_x8 = {base_i, 3'b000};
  assign base_x4 = {1'b0, base_i, 2'b00};
  assign strd_x8 = PTR_W'({stride_i, 3'b000});
  assign strd_x4 = PTR_W'({stride_i, 2'b00});

  assign start_o  = (mode16_i ? base_x4 : base_x8) + PTR_W'(sub_off_i);
  assign stride_o = mode16_i ? strd_x4 : strd_x8;

  always_comb begin
    unique case (depth_i)
      bmp_addr_pkg::BPP1: step_o = PTR_W'(1);
      bmp_addr_pkg::BPP2: step_o = PTR_W'(2);
      bmp_addr_pkg::BPP4: step_o = PTR_W'(4);
      default:            step_o = PTR_W'(8);
    endcase
  end

endmodule

// File: rtl/bmp_ptr.sv
module bmp_ptr #(
  parameter int unsigned PTR_W = 23
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  bmp_addr_pkg::ptr_op_e op_i,
  input  logic [PTR_W-1:0]      start_i,
  input  logic [PTR_W-1:0]      stride_i,
  input  logic [PTR_W-1:0]      step_i,
  output logic [PTR_W-1:0]      line_ptr_o,
  output logic [PTR_W-1:0]      cur_ptr_o
);

  logic [PTR_W-1:0] line_q, cur_q, line_nxt;

  assign line_nxt = line_q + stride_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      cur_q  <= '0;
    end else begin
      unique case (op_i)
        bmp_addr_pkg::OP_LOAD: begin
          line_q <= start_i;
          cur_q  <= start_i;
        end
        bmp_addr_pkg::OP_LINE: begin
          line_q <= line_nxt;
          cur_q  <= line_nxt;
        end
        bmp_addr_pkg::OP_STEP: cur_q <= cur_q + step_i;
        default: ;
      endcase
    end
  end

  assign line_ptr_o = line_q;
  assign cur_ptr_o  = cur_q;

endmodule

// File: rtl/bmp_addr_gen.sv
module bmp_addr_gen #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned REP_W    = 4,
  localparam int unsigned BIT_W   = bmp_addr_pkg::BIT_W,
  localparam int unsigned PTR_W   = ADDR_W + BIT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                first_line_i,
  input  logic                line_adv_i,
  input  logic                pix_en_i,
  input  logic                win_active_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [BIT_W-1:0]    sub_off_i,
  input  logic [1:0]          depth_i,
  input  logic                mode16_i,
  input  logic [REP_W-1:0]    rep_i,
  output logic [ADDR_W-1:0]   byte_addr_o,
  output logic [BIT_W-1:0]    bit_idx_o
);

  import bmp_addr_pkg::*;

  logic             restart, pix_tick, pix_step;
  logic [PTR_W-1:0] start_bits, stride_bits, step_bits;
  logic [PTR_W-1:0] line_ptr, cur_ptr;
  logic [ADDR_W-1:0] byte_part;
  ptr_op_e          op;

  assign restart  = first_line_i | line_adv_i;
  assign pix_tick = win_active_i & pix_en_i;

  bmp_hrep #(.REP_W(REP_W)) i_hrep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_i   (pix_tick),
    .rep_i    (rep_i),
    .step_o   (pix_step)
  );

  bmp_scale #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) i_scale (
    .base_i   (base_i),
    .stride_i (stride_i),
    .sub_off_i(sub_off_i),
    .mode16_i (mode16_i),
    .depth_i  (depth_e'(depth_i)),
    .start_o  (start_bits),
    .stride_o (stride_bits),
    .step_o   (step_bits)
  );

  always_comb begin
    if (first_line_i)    op = OP_LOAD;
    else if (line_adv_i) op = OP_LINE;
    else if (pix_step)   op = OP_STEP;
    else                 op = OP_HOLD;
  end

  bmp_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .start_i   (start_bits),
    .stride_i  (stride_bits),
    .step_i    (step_bits),
    .line_ptr_o(line_ptr),
    .cur_ptr_o (cur_ptr)
  );

  assign byte_part   = cur_ptr[PTR_W-1:BIT_W];
  assign bit_idx_o   = cur_ptr[BIT_W-1:0];
  assign byte_addr_o = mode16_i ? {byte_part[ADDR_W-2:0], 1'b0} : byte_part;

endmodule

// File: rtl/bmp_addr_chk.sv
module bmp_addr_chk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned REP_W    = 4,
  localparam int unsigned PTR_W   = ADDR_W + 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                first_line_i,
  input logic                line_adv_i,
  input logic                pix_en_i,
  input logic                win_active_i,
  input logic [ADDR_W-1:0]   base_i,
  input logic [2:0]          sub_off_i,
  input logic [1:0]          depth_i,
  input logic                mode16_i,
  input logic [REP_W-1:0]    rep_i,
  input logic [ADDR_W-1:0]   byte_addr_o,
  input logic [2:0]          bit_idx_o,
  input logic                pix_step,
  input logic [PTR_W-1:0]    line_ptr,
  input logic [PTR_W-1:0]    cur_ptr
);

  logic [REP_W-1:0] tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tick_cnt <= '0;
    else if (first_line_i || line_adv_i)  tick_cnt <= '0;
    else if (pix_step)                    tick_cnt <= '0;
    else if (win_active_i && pix_en_i)    tick_cnt <= tick_cnt + 1'b1;
  end

  // R2 and R8: a load wins over a line advance in the same cycle
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_line_i && (!mode16_i || !base_i[0]) |=>
      ($past(mode16_i) != mode16_i) ||
      (byte_addr_o == $past(base_i) && bit_idx_o == $past(sub_off_i)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_step && !first_line_i && !line_adv_i |=>
      cur_ptr == $past(cur_ptr) + (PTR_W'(1) << $past(depth_i)));

  p_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_adv_i && !first_line_i |=> cur_ptr == line_ptr);

  p_rep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_step |-> win_active_i && pix_en_i && tick_cnt == rep_i);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_active_i && !first_line_i && !line_adv_i |=>
      $stable(cur_ptr) && $stable(line_ptr));

endmodule

bind bmp_addr_gen bmp_addr_chk #(
  .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .REP_W(REP_W)
) i_bmp_addr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .first_line_i(first_line_i),
  .line_adv_i  (line_adv_i),
  .pix_en_i    (pix_en_i),
  .win_active_i(win_active_i),
  .base_i      (base_i),
  .sub_off_i   (sub_off_i),
  .depth_i     (depth_i),
  .mode16_i    (mode16_i),
  .rep_i       (rep_i),
  .byte_addr_o (byte_addr_o),
  .bit_idx_o   (bit_idx_o),
  .pix_step    (pix_step),
  .line_ptr    (line_ptr),
  .cur_ptr     (cur_ptr)
);

// File: tb/test_bmp_addr_gen.sv
`timescale 1ns/1ps
module test_bmp_addr_gen;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned STRIDE_W = 16;
  localparam int unsigned REP_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic first_line_i = 1'b0, line_adv_i = 1'b0, pix_en_i = 1'b0, win_active_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [STRIDE_W-1:0] stride_i = '0;
  logic [2:0] sub_off_i = '0;
  logic [1:0] depth_i = '0;
  logic mode16_i = 1'b0;
  logic [REP_W-1:0] rep_i = '0;
  logic [ADDR_W-1:0] byte_addr_o;
  logic [2:0] bit_idx_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bmp_addr_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .REP_W(REP_W)) i_bmp_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .first_line_i(first_line_i), .line_adv_i(line_adv_i),
    .pix_en_i(pix_en_i), .win_active_i(win_active_i), .base_i(base_i), .stride_i(stride_i),
    .sub_off_i(sub_off_i), .depth_i(depth_i), .mode16_i(mode16_i), .rep_i(rep_i),
    .byte_addr_o(byte_addr_o), .bit_idx_o(bit_idx_o)
  );

  task automatic chk(input string req, input logic [ADDR_W-1:0] ea, input logic [2:0] eb);
    n_run++;
    if (byte_addr_o !== ea || bit_idx_o !== eb) begin
      n_fail++;
      $display("FAIL %s: addr=%h bit=%0d expected addr=%h bit=%0d", req, byte_addr_o,
               bit_idx_o, ea, eb);
    end
  endtask

  // one clock: pulses set at falling edge, captured at rising edge, cleared after
  task automatic cyc(input logic fl, input logic la, input logic pe);
    first_line_i = fl; line_adv_i = la; pix_en_i = pe;
    @(posedge clk);
    @(negedge clk);
    first_line_i = 1'b0; line_adv_i = 1'b0; pix_en_i = 1'b0;
  endtask

  task automatic setup(input logic [ADDR_W-1:0] b, input logic [2:0] s, input logic [1:0] d,
                       input logic m, input logic [REP_W-1:0] r);
    base_i = b; sub_off_i = s; depth_i = d; mode16_i = m; rep_i = r;
    win_active_i = 1'b1;
    cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset", '0, 3'd0);
  endtask

  task automatic t_load;
    setup(20'h01234, 3'd5, 2'd0, 1'b0, '0);
    chk("R2 load normal", 20'h01234, 3'd5);
    setup(20'h02468, 3'd3, 2'd0, 1'b1, '0);
    chk("R2 load wide", 20'h02468, 3'd3);
  endtask

  task automatic t_depth;
    for (int d = 0; d < 4; d++) begin
      int bits;
      setup(20'h00100, 3'd0, 2'(d), 1'b0, '0);
      for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b1);
      bits = 5 << d;
      chk($sformatf("R3 depth %0d", d), 20'h00100 + 20'(bits / 8), 3'(bits % 8));
    end
  endtask

  task automatic t_wide;
    setup(20'h00200, 3'd0, 2'd3, 1'b1, '0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R4 wide step 1", 20'h00202, 3'd0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R4 wide step 3", 20'h00206, 3'd0);
    setup(20'h00200, 3'd0, 2'd2, 1'b1, '0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1);
    chk("R4 wide 4bpp", 20'h00202, 3'd4);
  endtask

  task automatic t_line;
    stride_i = 16'h0050;
    setup(20'h00300, 3'd2, 2'd3, 1'b0, '0);
    for (int k = 0; k < 7; k++) cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R5 line 1", 20'h00350, 3'd2);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R5 line 2", 20'h003A0, 3'd2);
    stride_i = 16'h0040;
    setup(20'h00400, 3'd0, 2'd3, 1'b1, '0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R5 line wide", 20'h00440, 3'd0);
  endtask

  task automatic t_rep;
    setup(20'h00500, 3'd0, 2'd3, 1'b0, 4'd2);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6 no step before wrap", 20'h00500, 3'd0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6 step on third tick", 20'h00501, 3'd0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1);
    chk("R6 second step", 20'h00502, 3'd0);
    stride_i = 16'h0010;
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6 restart on line", 20'h00510, 3'd0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6 step after restart", 20'h00511, 3'd0);
  endtask

  task automatic t_hold;
    setup(20'h00600, 3'd0, 2'd3, 1'b0, 4'd1);
    cyc(1'b0, 1'b0, 1'b1);
    win_active_i = 1'b0;
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b1);
    chk("R7 hold inactive", 20'h00600, 3'd0);
    win_active_i = 1'b1;
    cyc(1'b0, 1'b0, 1'b1);
    chk("R7 count held", 20'h00601, 3'd0);
  endtask

  task automatic t_prio;
    stride_i = 16'h0020;
    setup(20'h00700, 3'd1, 2'd3, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R8 load wins", 20'h00700, 3'd1);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R8 line wins over step", 20'h00720, 3'd1);
  endtask

  task automatic t_wrap;
    setup(20'hFFFFF, 3'd0, 2'd3, 1'b0, '0);
    chk("R9 top byte", 20'hFFFFF, 3'd0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R9 wrap", 20'h00000, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_depth();
    t_wide();
    t_line();
    t_rep();
    t_hold();
    t_prio();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule